// File: doc/BRIEF.md
# Partitioned SRAM Access Sequencer

This block is a synchronous access controller wrapped around a behavioural storage array that is split into independently enabled banks. Each access cycle is cut into a fixed number of phases by a fast phase counter. The sequencer accepts one request per access cycle and splits the registered address into a bank number, a row and a word within the row. Only the addressed bank is enabled, and the bank-local strobes are issued in a strict order: precharge, then a short wordline pulse, then sense-enable on a read. On a write, the bitline drive comes first and the wordline follows it.

The sense-enable pulse is chained off the end of the wordline pulse rather than launched from the phase counter. The write wordline is in the same way launched by the first cycle of bitline drive. Row selection is done in two levels: a one-hot group predecode gates the wordline pulse into one row group, and a small decoder then picks the row inside that group. Read data is captured at the end of the sense-enable pulse and is held on the output until the next read replaces it.

The strobes and bank enables are brought out as ports so that the ordering can be checked. With the default parameters the array has 32 banks, each of 16 rows of four 32-bit words. The row-decode widths are parameters, so the full-size row count is reached by overriding them.

Top module: `sram_seq_top`

## Requirements
- R1: A word written to an address is returned by a later read of the same address. The address splits as addr_i[10:6] for the bank, addr_i[5:2] for the row and addr_i[1:0] for the word in the row.
- R2: During an access, exactly one bit of blk_en_o is high, at position addr_i[10:6] of the request. In an idle access cycle, all bits of blk_en_o are low.
- R3: phase_o counts 0,1,...,7 and wraps to 0, one step per clock. A request present while phase_o is 7 is captured at that edge, and its access occupies phases 0 to 7 of the following cycle.
- R4: pre_o is high only in phase 0 of a read or write access, and never together with wl_o, sae_o or wdrv_o.
- R5: On a read, wl_o is high in phases 1 and 2 only.
- R6: On a read, sae_o is high in phases 3 and 4 only. It rises only in the cycle directly after wl_o was high, and it is never high together with wl_o.
- R7: On a write, wdrv_o is high in phases 3, 4 and 5 and wl_o is high in phases 4 and 5. sae_o stays low, and wl_o never rises without wdrv_o having been high in the previous cycle.
- R8: rdata_o takes the read word in phase 5 of a read access. At every other phase, and through idle and write accesses, it keeps its previous value.
- R9: If rd_i and wr_i are both high for one request, the access is a write, and rdata_o keeps its previous value.
- R10: While rst_n is low, blk_en_o, pre_o, wl_o, sae_o and wdrv_o are low, and phase_o and rdata_o are zero.
- R11: Addresses that differ only in the row-group bits addr_i[5:4], the in-group row bits addr_i[3:2], the word bits addr_i[1:0] or the bank bits each reach separate storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast phase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_i | input | 1 | Read request, sampled in phase 7 |
| wr_i | input | 1 | Write request, sampled in phase 7; wins over rd_i |
| addr_i | input | 11 | Word address: bank, row, word in row |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, held between reads |
| phase_o | output | 3 | Current phase within the access cycle |
| blk_en_o | output | 32 | One-hot bank enable |
| pre_o | output | 1 | Bitline precharge strobe |
| wl_o | output | 1 | Wordline pulse of the enabled bank |
| sae_o | output | 1 | Sense-enable pulse |
| wdrv_o | output | 1 | Write bitline drive strobe |

## Verification
On every clock, the bound checker enforces the following: at most one bank enable, the phase stepping, precharge exclusive of the other strobes, sense-enable never overlapping the wordline and always following it, the write wordline always preceded by bitline drive, and read data moving only in its update phase. The exact phase position of each strobe, the choice of bank, collision priority and whether stored data survives can only be shown by the bench scenarios. The bench compares each access against a reference memory, with directed cases on row-group, row, word and bank boundaries and on simultaneous read and write.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

   typedef enum logic [1:0] {
      OP_IDLE = 2'd0,
      OP_RD   = 2'd1,
      OP_WR   = 2'd2
   } op_e;

   // phase plan of one access cycle
   localparam int PH_PRE      = 0;                 // precharge phase
   localparam int PH_WL_FIRE  = 0;                 // read wordline launched at end of this phase
   localparam int WL_LEN      = 2;                 // wordline pulse length
   localparam int SAE_LEN     = 2;                 // sense-enable pulse length
   localparam int PH_DRV_FIRE = 2;                 // write drive launched at end of this phase
   localparam int DRV_LEN     = WL_LEN + 1;        // drive covers the whole write wordline
   localparam int RD_UPD_PH   = PH_WL_FIRE + WL_LEN + SAE_LEN + 1;
   localparam int MIN_PHASES  = PH_DRV_FIRE + DRV_LEN + 2;

endpackage

// File: rtl/seq_pulse.sv
module seq_pulse #(
   parameter int LEN = 2,
   parameter int TAP = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic active,
   output logic tap
);
   localparam int CW = $clog2(LEN + 1);

   generate
      if (LEN < 1 || TAP < 1 || TAP > LEN) begin : g_bad
         $error("seq_pulse: TAP must lie in 1..LEN");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (fire)         cnt <= CW'(LEN);
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign active = (cnt != '0);
   assign tap    = (cnt == CW'(TAP));
endmodule

// File: rtl/seq_bank.sv
module seq_bank #(
   parameter int GRP_W  = 2,
   parameter int LO_W   = 2,
   parameter int WSEL_W = 2,
   parameter int DW     = 32
) (
   input  logic                    clk,
   input  logic                    en,
   input  logic                    drv,
   input  logic [(1<<GRP_W)-1:0]   wl_grp,
   input  logic [(1<<LO_W)-1:0]    lo_sel,
   input  logic [WSEL_W-1:0]       word,
   input  logic [DW-1:0]           wdata,
   input  logic [GRP_W+LO_W-1:0]   rd_row,
   output logic [DW-1:0]           rdata
);
   localparam int NGRP  = 1 << GRP_W;
   localparam int NLO   = 1 << LO_W;
   localparam int DEPTH = 1 << (GRP_W + LO_W + WSEL_W);

   logic [DW-1:0] mem [DEPTH];

   // two-level row select: gated group wordline and in-group row line
   always_ff @(posedge clk) begin
      if (en && drv) begin
         for (int g = 0; g < NGRP; g++) begin
            for (int r = 0; r < NLO; r++) begin
               if (wl_grp[g] && lo_sel[r])
                  mem[{GRP_W'(g), LO_W'(r), word}] <= wdata;
            end
         end
      end
   end

   assign rdata = mem[{rd_row, word}];
endmodule

// File: rtl/sram_seq_top.sv
module sram_seq_top
   import sram_seq_pkg::*;
#(
   parameter int BLK_W  = 5,
   parameter int GRP_W  = 2,
   parameter int LO_W   = 2,
   parameter int WSEL_W = 2,
   parameter int DW     = 32,
   parameter int NPH    = 8,
   localparam int AW    = BLK_W + GRP_W + LO_W + WSEL_W,
   localparam int NBLK  = 1 << BLK_W,
   localparam int PH_W  = $clog2(NPH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_i,
   input  logic             wr_i,
   input  logic [AW-1:0]    addr_i,
   input  logic [DW-1:0]    wdata_i,
   output logic [DW-1:0]    rdata_o,
   output logic [PH_W-1:0]  phase_o,
   output logic [NBLK-1:0]  blk_en_o,
   output logic             pre_o,
   output logic             wl_o,
   output logic             sae_o,
   output logic             wdrv_o
);
   localparam int NGRP = 1 << GRP_W;
   localparam int NLO  = 1 << LO_W;

   generate
      if (NPH < MIN_PHASES || NPH <= RD_UPD_PH) begin : g_bad_ph
         $error("sram_seq_top: NPH too small for the phase plan");
      end
      if (BLK_W < 1 || GRP_W < 1 || LO_W < 1 || WSEL_W < 1 || DW < 1) begin : g_bad_w
         $error("sram_seq_top: field widths must be at least 1");
      end
   endgenerate

   // phase counter
   logic [PH_W-1:0] ph;
   logic            cyc_end;

   assign cyc_end = (ph == PH_W'(NPH - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ph <= '0;
      else if (cyc_end) ph <= '0;
      else              ph <= ph + 1'b1;
   end

   // input gating register: one request per access cycle, write wins
   op_e            op_kind;
   logic [AW-1:0]  op_addr;
   logic [DW-1:0]  op_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_kind <= OP_IDLE;
         op_addr <= '0;
         op_data <= '0;
      end else if (cyc_end) begin
         op_kind <= wr_i ? OP_WR : (rd_i ? OP_RD : OP_IDLE);
         op_addr <= addr_i;
         op_data <= wdata_i;
      end
   end

   logic [BLK_W-1:0]  op_blk;
   logic [GRP_W-1:0]  op_grp;
   logic [LO_W-1:0]   op_lo;
   logic [WSEL_W-1:0] op_word;
   logic              is_rd, is_wr;

   assign op_blk  = op_addr[AW-1 -: BLK_W];
   assign op_grp  = op_addr[WSEL_W + LO_W +: GRP_W];
   assign op_lo   = op_addr[WSEL_W +: LO_W];
   assign op_word = op_addr[WSEL_W-1:0];
   assign is_rd   = (op_kind == OP_RD);
   assign is_wr   = (op_kind == OP_WR);

   // chained strobe generation
   logic wl, wl_end, sae, sae_end, drv, drv_start;
   logic wl_fire, sae_fire, drv_fire;

   assign drv_fire = is_wr && (ph == PH_W'(PH_DRV_FIRE));
   assign wl_fire  = (is_rd && (ph == PH_W'(PH_WL_FIRE))) || (is_wr && drv_start);
   assign sae_fire = is_rd && wl_end;

   seq_pulse #(.LEN(DRV_LEN), .TAP(DRV_LEN)) u_drv (
      .clk(clk), .rst_n(rst_n), .fire(drv_fire), .active(drv), .tap(drv_start));

   seq_pulse #(.LEN(WL_LEN), .TAP(1)) u_wl (
      .clk(clk), .rst_n(rst_n), .fire(wl_fire), .active(wl), .tap(wl_end));

   seq_pulse #(.LEN(SAE_LEN), .TAP(1)) u_sae (
      .clk(clk), .rst_n(rst_n), .fire(sae_fire), .active(sae), .tap(sae_end));

   // bank enable and two-level row predecode
   logic [NBLK-1:0] blk_en;
   logic [NGRP-1:0] wl_grp;
   logic [NLO-1:0]  lo_sel;
   logic [DW-1:0]   bank_rd [NBLK];

   assign wl_grp = (NGRP'(1) << op_grp) & {NGRP{wl}};
   assign lo_sel = NLO'(1) << op_lo;

   genvar b;
   generate
      for (b = 0; b < NBLK; b++) begin : g_bank
         assign blk_en[b] = (op_kind != OP_IDLE) && (op_blk == BLK_W'(b));

         seq_bank #(.GRP_W(GRP_W), .LO_W(LO_W), .WSEL_W(WSEL_W), .DW(DW)) u_bank (
            .clk    (clk),
            .en     (blk_en[b]),
            .drv    (drv),
            .wl_grp (wl_grp),
            .lo_sel (lo_sel),
            .word   (op_word),
            .wdata  (op_data),
            .rd_row ({op_grp, op_lo}),
            .rdata  (bank_rd[b]));
      end
   endgenerate

   // output latch: captured at the end of sense-enable, held otherwise
   logic [DW-1:0] rdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                rdata_q <= '0;
      else if (is_rd && sae_end) rdata_q <= bank_rd[op_blk];
   end

   assign rdata_o  = rdata_q;
   assign phase_o  = ph;
   assign blk_en_o = blk_en;
   assign pre_o    = (op_kind != OP_IDLE) && (ph == PH_W'(PH_PRE));
   assign wl_o     = wl;
   assign sae_o    = sae;
   assign wdrv_o   = drv;
endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk
   import sram_seq_pkg::*;
#(
   parameter int NBLK = 32,
   parameter int DW   = 32,
   parameter int NPH  = 8,
   parameter int PH_W = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic [PH_W-1:0] phase,
   input logic [NBLK-1:0] blk_en,
   input logic            pre,
   input logic            wl,
   input logic            sae,
   input logic            wdrv,
   input logic [DW-1:0]   rdata
);
   // R2
   blk_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(blk_en));

   // R3
   phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (phase == (($past(phase) == PH_W'(NPH - 1)) ? PH_W'(0)
                                                                   : PH_W'($past(phase) + 1'b1))));

   // R4
   pre_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pre |-> !(wl || sae || wdrv));

   // R6
   sae_wl_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(sae && wl));

   // R6
   sae_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sae) |-> $past(wl));

   // R7
   wr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(wl) && wdrv) |-> $past(wdrv));

   // R8
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && (phase != PH_W'(RD_UPD_PH))) |-> $stable(rdata));
endmodule

bind sram_seq_top sram_seq_chk #(.NBLK(NBLK), .DW(DW), .NPH(NPH), .PH_W(PH_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .phase  (phase_o),
   .blk_en (blk_en_o),
   .pre    (pre_o),
   .wl     (wl_o),
   .sae    (sae_o),
   .wdrv   (wdrv_o),
   .rdata  (rdata_o));

// File: tb/sim_sram_seq_top.sv
module sim_sram_seq_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_i = 1'b0, wr_i = 1'b0;
   logic [10:0] addr_i = '0;
   logic [31:0] wdata_i = '0;
   logic [31:0] rdata_o;
   logic [2:0]  phase_o;
   logic [31:0] blk_en_o;
   logic        pre_o, wl_o, sae_o, wdrv_o;

   int checks = 0, failures = 0;
   bit done = 0;

   logic [31:0] ref_mem [2048];
   logic [10:0] wlist [64];
   int          wcnt = 0;
   logic [31:0] exp_rd = '0;

   always #10 clk = ~clk;

   sram_seq_top u0 (
      .clk(clk), .rst_n(rst_n), .rd_i(rd_i), .wr_i(wr_i), .addr_i(addr_i),
      .wdata_i(wdata_i), .rdata_o(rdata_o), .phase_o(phase_o), .blk_en_o(blk_en_o),
      .pre_o(pre_o), .wl_o(wl_o), .sae_o(sae_o), .wdrv_o(wdrv_o));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
      end
   endtask

   // {pre, wl, sae, wdrv} per phase; kind 0 idle, 1 read, 2 write
   function automatic logic [3:0] exp_ctl(input int k, input int kind);
      logic p, w, s, d;
      p = (kind != 0) && (k == 0);
      w = (kind == 1 && (k == 1 || k == 2)) || (kind == 2 && (k == 4 || k == 5));
      s = (kind == 1) && (k == 3 || k == 4);
      d = (kind == 2) && (k >= 3 && k <= 5);
      return {p, w, s, d};
   endfunction

   task automatic access(input logic r, input logic w, input logic [10:0] a, input logic [31:0] d);
      int kind;
      logic [31:0] old_rd, new_rd;
      string tag;
      kind = w ? 2 : (r ? 1 : 0);
      while (phase_o != 3'd7) @(negedge clk);
      rd_i = r; wr_i = w; addr_i = a; wdata_i = d;
      old_rd = exp_rd;
      new_rd = (kind == 1) ? ref_mem[a] : old_rd;
      if (kind == 2) begin
         ref_mem[a] = d;
         wlist[wcnt % 64] = a;
         wcnt++;
      end
      tag = (kind == 1) ? "R5/R6 read strobes" : (kind == 2) ? "R7 write strobes" : "R4 idle strobes";
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         chk("R3 phase", 64'(phase_o), 64'(k));
         chk(tag, 64'({pre_o, wl_o, sae_o, wdrv_o}), 64'(exp_ctl(k, kind)));
         chk("R2 bank enable", 64'(blk_en_o), (kind != 0) ? (64'd1 << a[10:6]) : 64'd0);
         chk((r && w) ? "R9 collision rdata" : "R8/R1 rdata", 64'(rdata_o),
             64'((kind == 1 && k >= 5) ? new_rd : old_rd));
      end
      exp_rd = new_rd;
   endtask

   initial begin
      void'($urandom(32'd4711));
      // R10 reset state
      repeat (3) @(negedge clk);
      chk("R10 reset blk_en", 64'(blk_en_o), 64'd0);
      chk("R10 reset strobes", 64'({pre_o, wl_o, sae_o, wdrv_o}), 64'd0);
      chk("R10 reset phase", 64'(phase_o), 64'd0);
      chk("R10 reset rdata", 64'(rdata_o), 64'd0);
      rst_n = 1'b1;

      // R1 basic write then read
      access(0, 1, 11'h123, 32'hDEADBEEF);
      access(1, 0, 11'h123, '0);
      // R11 neighbours in word, in-group row, row group and bank
      access(0, 1, 11'h120, 32'h0000_0A00);
      access(0, 1, 11'h121, 32'h0000_0A01);
      access(0, 1, 11'h122, 32'h0000_0A02);
      access(0, 1, 11'h127, 32'h0000_0B03);
      access(0, 1, 11'h133, 32'h0000_0C03);
      access(0, 1, 11'h163, 32'h0000_0D03);
      access(0, 1, 11'h523, 32'h0000_0E03);
      access(0, 1, 11'h7FF, 32'hFFFF_0001);
      access(0, 1, 11'h000, 32'h1234_5678);
      access(1, 0, 11'h120, '0);
      access(1, 0, 11'h121, '0);
      access(1, 0, 11'h122, '0);
      access(1, 0, 11'h123, '0);
      access(1, 0, 11'h127, '0);
      access(1, 0, 11'h133, '0);
      access(1, 0, 11'h163, '0);
      access(1, 0, 11'h523, '0);
      access(1, 0, 11'h7FF, '0);
      access(1, 0, 11'h000, '0);
      // R2 idle cycle enables nothing; R8 rdata held
      access(0, 0, 11'h3AA, '0);
      // R9 read and write together: write wins, rdata unchanged
      access(1, 1, 11'h123, 32'hCAFE_F00D);
      access(1, 0, 11'h123, '0);

      for (int i = 0; i < 300; i++) begin
         int sel;
         sel = $urandom_range(0, 9);
         if (sel < 4 || wcnt == 0)
            access(0, 1, 11'($urandom()), $urandom());
         else if (sel < 8)
            access(1, 0, wlist[$urandom_range(0, (wcnt < 64 ? wcnt : 64) - 1)], '0);
         else if (sel == 8)
            access(0, 0, 11'($urandom()), '0);
         else
            access(1, 1, 11'($urandom()), $urandom());
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule